// File: doc/BRIEF.md
# Column-End Readout Synchronizer

This block sits below a pixel matrix organised as double-columns. Each double-column presents a 22-bit hit packet together with a request line, and waits for an acknowledge before it removes the request. The block treats every request as asynchronous and passes it through a two-stage synchronizer. It picks one pending column and latches that column's packet. It adds the 5-bit column number above the packet and returns the acknowledge from a register.

The resulting 27-bit record leaves as three 9-bit beats on a valid/ready stream, most significant beat first. The third beat carries a last flag. A test mode limits service to one column chosen by a select input, so a single double-column can be read in isolation. In normal mode, pending columns are served in round-robin order. Only one record is in flight at any time.

Top module: `colend_sync`

## Requirements
- R1: A synchronous active-low reset clears every acknowledge, drops the output valid, and sets the rotation so that column 0 has the highest priority on the first grant.
- R2: A request passes two synchronizer flops. When the block is idle, the acknowledge and output valid rise at the third rising clock edge that samples the request high.
- R3: The record is {column number[4:0], packet[21:0]}. It is sent as beat 0 = bits 26:18, beat 1 = bits 17:9, beat 2 = bits 8:0.
- R4: The last flag is high on beat 2 only, and never while valid is low.
- R5: While valid is high and ready is low, the beat and the last flag hold steady. The beat advances only on a cycle with valid and ready both high.
- R6: An acknowledge stays high while the request stays high. It falls at the third rising edge that samples the request low.
- R7: At most one acknowledge is high at a time. No column is granted while any acknowledge is high or while beats of a record are still unaccepted.
- R8: In normal mode, after column k is served, the next grant goes to the pending column with the lowest number above k, wrapping from 31 to 0.
- R9: With the test mode enabled, only the column equal to the 5-bit select is granted. Other requests receive no acknowledge and produce no output. With the test mode disabled, the select has no effect.
- R10: With ready held high, the three beats of a record appear on three consecutive cycles, and valid falls in the cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_req | input | 32 | Per-column request, asynchronous |
| col_data | input | 704 | Packets of all columns, column c at bits c*22 +: 22 |
| col_ack | output | 32 | Per-column acknowledge, registered |
| test_en | input | 1 | Enable the single-column test mode |
| test_sel | input | 5 | Column served while the test mode is enabled |
| out_data | output | 9 | Current output beat |
| out_last | output | 1 | Marks the third beat of a record |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Consumer accepts the beat |

## Verification
The bench builds the block with 32 columns, 22-bit packets and a 9-bit output word, the values the block defaults to. A 27-bit record therefore splits into three full beats with no padding, which makes every bit position of every beat checkable. Using all 32 columns lets the bench reach column 31, where the address is all ones and the round-robin search wraps to column 0. It also lets the bench set the test-mode select to values far from the requesting column.

// File: rtl/colend_pkg.sv
// Package: shared helpers for the column-end synchronizer.
// Assumes nothing beyond positive widths.
package colend_pkg;

    // Number of output words needed to carry a record of rec_w bits.
    function automatic int beats_for(input int rec_w, input int ow);
        return (rec_w + ow - 1) / ow;
    endfunction

endpackage

// File: rtl/colend_sync2.sv
// Module: two-flop synchronizer bank for asynchronous request lines.
// Assumes each input bit changes no faster than the handshake allows
// (four-phase), so bits may be synchronized independently.
module colend_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/colend_rr_arb.sv
// Module: round-robin arbiter. The search starts one above the last
// winner and wraps. Assumes N >= 2. The grant is combinational and
// qualified by en; the pointer moves only when a grant is issued.
module colend_rr_arb #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] win_idx
);
    logic [IW-1:0] last_q;
    logic          found;

    // Pick the first requester after last_q in circular order.
    always_comb begin
        grant   = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(last_q) + off) % N;
            if (!found && req[IW'(idx)]) begin
                found   = 1'b1;
                win_idx = IW'(idx);
            end
        end
        if (en && found) grant[win_idx] = 1'b1;
    end

    // Remember the winner; reset makes column 0 the first in line.
    always_ff @(posedge clk) begin
        if (!rst_n)          last_q <= IW'(N - 1);
        else if (en && found) last_q <= win_idx;
    end
endmodule

// File: rtl/colend_ser.sv
// Module: record-to-beat serializer with valid/ready output.
// Loads a record when load is high (the caller guarantees !busy) and
// sends it most significant beat first. A short record is zero-padded
// at the top.
module colend_ser #(
    parameter int REC_W = 27,
    parameter int OW    = 9,
    localparam int BEATS = colend_pkg::beats_for(REC_W, OW),
    localparam int PW    = BEATS * OW,
    localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REC_W-1:0] rec,
    output logic             busy,
    output logic [OW-1:0]    out_data,
    output logic             out_last,
    output logic             out_valid,
    input  logic             out_ready
);
    logic [PW-1:0] hold_q;
    logic [CW-1:0] cnt_q;

    // Hold the record and step through its beats on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            cnt_q  <= '0;
            hold_q <= PW'(rec);
        end else if (busy && out_ready) begin
            if (cnt_q == CW'(BEATS - 1)) begin
                busy  <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Select the current beat, highest slice first.
    always_comb begin
        out_valid = busy;
        out_last  = busy && (cnt_q == CW'(BEATS - 1));
        out_data  = hold_q[(BEATS - 1 - int'(cnt_q)) * OW +: OW];
    end
endmodule

// File: rtl/colend_sync.sv
// Module: column-end readout synchronizer (top).
// Synchronizes per-column requests, arbitrates (round-robin, or a
// single selected column in test mode), tags the packet with its column
// number, acknowledges from a register and streams the record as narrow
// beats. Assumes four-phase handshakes with data stable while req is high.
module colend_sync #(
    parameter int NCOL = 32,
    parameter int DW   = 22,
    parameter int OW   = 9,
    localparam int AW    = $clog2(NCOL),
    localparam int REC_W = DW + AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCOL-1:0]    col_req,
    input  logic [NCOL*DW-1:0] col_data,
    output logic [NCOL-1:0]    col_ack,
    input  logic               test_en,
    input  logic [AW-1:0]      test_sel,
    output logic [OW-1:0]      out_data,
    output logic               out_last,
    output logic               out_valid,
    input  logic               out_ready
);
    logic [NCOL-1:0]  req_s;
    logic [NCOL-1:0]  sel_mask;
    logic [NCOL-1:0]  grant;
    logic [AW-1:0]    win_idx;
    logic             ser_busy;
    logic             arb_en;
    logic [DW-1:0]    win_data;
    logic [REC_W-1:0] rec;

    colend_sync2 #(.W(NCOL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (col_req),
        .q     (req_s)
    );

    // Test-mode mask: with the test mode on, only the selected column passes.
    for (genvar i = 0; i < NCOL; i++) begin : g_mask
        assign sel_mask[i] = !test_en || (test_sel == AW'(i));
    end

    // Grant only when no handshake is open and no beat is outstanding.
    assign arb_en = !ser_busy && (col_ack == '0);

    colend_rr_arb #(.N(NCOL)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (arb_en),
        .req     (req_s & sel_mask),
        .grant   (grant),
        .win_idx (win_idx)
    );

    // Tag the winning packet with its column number.
    always_comb begin
        win_data = col_data[int'(win_idx) * DW +: DW];
        rec      = {win_idx, win_data};
    end

    // Registered acknowledges: set on grant, cleared once req is seen low.
    for (genvar i = 0; i < NCOL; i++) begin : g_ack
        always_ff @(posedge clk) begin
            if (!rst_n)        col_ack[i] <= 1'b0;
            else if (grant[i]) col_ack[i] <= 1'b1;
            else if (!req_s[i]) col_ack[i] <= 1'b0;
        end
    end

    colend_ser #(.REC_W(REC_W), .OW(OW)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (|grant),
        .rec       (rec),
        .busy      (ser_busy),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );
endmodule

// File: rtl/colend_sync_chk.sv
// Module: protocol checker for colend_sync, attached through bind.
// Observes ports only; assumes col_req is low while reset is applied.
module colend_sync_chk #(
    parameter int NCOL = 32,
    parameter int AW   = 5,
    parameter int OW   = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCOL-1:0] col_req,
    input logic [NCOL-1:0] col_ack,
    input logic            test_en,
    input logic [AW-1:0]   test_sel,
    input logic [OW-1:0]   out_data,
    input logic            out_last,
    input logic            out_valid,
    input logic            out_ready
);
    localparam logic [NCOL-1:0] ONE = NCOL'(1);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (col_ack == '0) && !out_valid);

    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|col_ack) |-> ((col_ack & $past(col_req, 3)) == col_ack));

    p_last_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

    p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|col_ack) |-> (($past(col_req, 2) & $past(col_ack)) == '0));

    p_single_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_ack));

    p_grant_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|col_ack) |-> out_valid && !$past(out_valid));

    p_test_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|col_ack) && $past(test_en)) |-> (col_ack == (ONE << $past(test_sel))));
endmodule

bind colend_sync colend_sync_chk #(.NCOL(NCOL), .AW(AW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_req   (col_req),
    .col_ack   (col_ack),
    .test_en   (test_en),
    .test_sel  (test_sel),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/colend_sync_bench.sv
// Bench for colend_sync: a vector table walked by one loop, plus
// directed tests for reset, timing, back-pressure and arbitration order.
module colend_sync_bench;
    localparam int NCOL = 32;
    localparam int DW   = 22;
    localparam int OW   = 9;
    localparam int AW   = 5;

    typedef struct packed {
        logic          ten;
        logic [4:0]    sel;
        logic [4:0]    col;
        logic [21:0]   data;
        logic          served;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 5'd0,  5'd1,  22'h000001, 1'b1},
        '{1'b0, 5'd9,  5'd31, 22'h3FFFFF, 1'b1},
        '{1'b1, 5'd12, 5'd12, 22'h0ABCDE, 1'b1},
        '{1'b1, 5'd12, 5'd13, 22'h111111, 1'b0},
        '{1'b1, 5'd31, 5'd31, 22'h2468AC, 1'b1},
        '{1'b1, 5'd0,  5'd31, 22'h135790, 1'b0},
        '{1'b0, 5'd0,  5'd16, 22'h200000, 1'b1},
        '{1'b1, 5'd0,  5'd0,  22'h000000, 1'b1}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NCOL-1:0]    col_req;
    logic [NCOL*DW-1:0] col_data;
    logic [NCOL-1:0]    col_ack;
    logic               test_en;
    logic [AW-1:0]      test_sel;
    logic [OW-1:0]      out_data;
    logic               out_last;
    logic               out_valid;
    logic               out_ready;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    colend_sync #(.NCOL(NCOL), .DW(DW), .OW(OW)) u_colend_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_req   (col_req),
        .col_data  (col_data),
        .col_ack   (col_ack),
        .test_en   (test_en),
        .test_sel  (test_sel),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    function automatic logic [OW-1:0] beat_of(input int col, input logic [DW-1:0] d, input int b);
        logic [26:0] r;
        r = {5'(col), d};
        return r[26 - 9 * b -: 9];
    endfunction

    task automatic wait_ack(input int c, output bit got);
        got = 1'b0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (col_ack[c]) got = 1'b1;
        end
    endtask

    // Drain one record with single-cycle ready pulses and compare each beat.
    task automatic collect(input int c, input logic [DW-1:0] d, input string tag);
        for (int b = 0; b < 3; b++) begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 20 && !seen; i++) begin
                if (out_valid) seen = 1'b1;
                else @(negedge clk);
            end
            chk(seen && out_data == beat_of(c, d, b), tag, 32'(out_data), 32'(beat_of(c, d, b)));
            chk(out_last == (b == 2), "R4 last flag on beat 2 only", 32'(out_last), 32'(b == 2));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    task automatic release_col(input int c);
        bit low;
        col_req[c] = 1'b0;
        low = 1'b0;
        for (int i = 0; i < 20 && !low; i++) begin
            @(negedge clk);
            if (!col_ack[c]) low = 1'b1;
        end
        chk(low, "R6 ack drops after req release", 32'(col_ack[c]), 32'd0);
    endtask

    task automatic put(input int c, input logic [DW-1:0] d);
        col_data[c * DW +: DW] = d;
        col_req[c] = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit got;
        int order [3];
        rst_n = 1'b0; col_req = '0; col_data = '0;
        test_en = 1'b0; test_sel = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(col_ack == '0, "R1 ack cleared in reset", col_ack, 32'd0);
        chk(!out_valid, "R1 valid low in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        // R1: column 0 side of the rotation wins first after reset.
        put(30, 22'h0F0F0F);
        put(3, 22'h30C30C);
        wait_ack(3, got);
        chk(got && col_ack == (32'd1 << 3), "R1 first grant to column 3 over 30", col_ack, 32'd1 << 3);
        collect(3, 22'h30C30C, "R3 record column 3");
        release_col(3);
        wait_ack(30, got);
        chk(got, "R8 column 30 served next", col_ack, 32'd1 << 30);
        collect(30, 22'h0F0F0F, "R3 record column 30");
        release_col(30);

        // R2, R10, R6: exact timing of the handshake and the beat stream.
        @(negedge clk);
        put(5, 22'h15A5C3);
        @(negedge clk);
        chk(col_ack == '0, "R2 no ack after one edge", col_ack, 32'd0);
        @(negedge clk);
        chk(col_ack == '0 && !out_valid, "R2 no ack after two edges", col_ack, 32'd0);
        @(negedge clk);
        chk(col_ack == (32'd1 << 5) && out_valid, "R2 ack at third edge", col_ack, 32'd1 << 5);
        out_ready = 1'b1;
        for (int b = 0; b < 3; b++) begin
            chk(out_valid && out_data == beat_of(5, 22'h15A5C3, b), "R10 back-to-back beat",
                32'(out_data), 32'(beat_of(5, 22'h15A5C3, b)));
            chk(out_last == (b == 2), "R4 last on consecutive stream", 32'(out_last), 32'(b == 2));
            @(negedge clk);
        end
        chk(!out_valid, "R10 valid low after last beat", 32'(out_valid), 32'd0);
        out_ready = 1'b0;
        col_req[5] = 1'b0;
        @(negedge clk);
        chk(col_ack[5], "R6 ack held one edge after release", 32'(col_ack[5]), 32'd1);
        @(negedge clk);
        chk(col_ack[5], "R6 ack held two edges after release", 32'(col_ack[5]), 32'd1);
        @(negedge clk);
        chk(!col_ack[5], "R6 ack low at third edge", 32'(col_ack[5]), 32'd0);

        // R5: stalled output holds its beat.
        put(7, 22'h3F00FF);
        wait_ack(7, got);
        chk(got, "R5 column 7 granted", col_ack, 32'd1 << 7);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid && !out_last && out_data == beat_of(7, 22'h3F00FF, 0), "R5 beat held under stall",
                32'(out_data), 32'(beat_of(7, 22'h3F00FF, 0)));
        end
        collect(7, 22'h3F00FF, "R5 record after stall");
        release_col(7);

        // R8, R7: three pending columns, last served was 7.
        order = '{10, 20, 2};
        put(2, 22'h222222);
        put(10, 22'h0AAAAA);
        put(20, 22'h141414);
        for (int k = 0; k < 3; k++) begin
            wait_ack(order[k], got);
            chk(got && col_ack == (32'd1 << order[k]), "R8 round-robin order", col_ack, 32'd1 << order[k]);
            repeat (3) @(negedge clk);
            chk(col_ack == (32'd1 << order[k]), "R7 no second grant while beats pending",
                col_ack, 32'd1 << order[k]);
            collect(order[k], col_data[order[k] * DW +: DW], "R3 record in round-robin");
            repeat (5) @(negedge clk);
            chk(col_ack == (32'd1 << order[k]) && !out_valid, "R7 no grant while an ack is open",
                col_ack, 32'd1 << order[k]);
            release_col(order[k]);
        end

        // Vector table: normal and test-mode service.
        for (int v = 0; v < 8; v++) begin
            test_en  = VEC[v].ten;
            test_sel = VEC[v].sel;
            put(int'(VEC[v].col), VEC[v].data);
            if (VEC[v].served) begin
                wait_ack(int'(VEC[v].col), got);
                chk(got, "R9 selected or normal column acknowledged", col_ack, 32'd1 << VEC[v].col);
                collect(int'(VEC[v].col), VEC[v].data, "R3 vector record");
                release_col(int'(VEC[v].col));
            end else begin
                repeat (12) @(negedge clk);
                chk(col_ack == '0 && !out_valid, "R9 unselected column ignored", col_ack, 32'd0);
                col_req[VEC[v].col] = 1'b0;
                repeat (5) @(negedge clk);
            end
        end
        test_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(col_ack == '0 && !out_valid, "R1 idle at end", col_ack, 32'd0);
        finish_run();
    end
endmodule